// File: doc/BRIEF.md
# DMA Channel Status Tracker

This block keeps the live status of a single DMA channel that carries USB endpoint packet data. It holds a channel-enable flag, a channel-active flag, a byte counter that runs down as data moves, and three sticky event flags: transfer ended by the device, buffer exhausted, and descriptor loaded. All of these are packed into one status word that software reads. Reading the word through the status-read strobe clears the sticky flags.

The channel is switched on or off in two ways: a write to the control enable bit, or a descriptor load that brings its own enable bit and a fresh byte count. Switching the channel off while it is sourcing a packet and its FIFO still holds data does not take effect at once. The block raises a drain request and holds the enable status high until the FIFO reports empty. When the channel is idle and the load-next control bit is set, the block requests the next descriptor.

Top module: `dma_chan_status`

## Requirements
- R1: While the synchronous active-low reset is asserted, and in the first cycle after it is released, the status word, `drainReq` and `nextDescReq` (with `ldNextCtl` low) are all zero.
- R2: A descriptor load writes `descCount` into status bits 31:16 and `descEnBit` into the enable bit (bit 0), and sets the descriptor-loaded flag (bit 6), all visible in the next cycle.
- R3: While the channel is enabled and the count is non-zero, each `byteStb` lowers the count by one. A strobe that arrives while the channel is disabled, or while the count is zero, leaves the status word unchanged.
- R4: The byte strobe that brings the count to zero sets the end-of-buffer flag (bit 5) and clears the enable bit.
- R5: A `devEnd` while the channel is enabled sets the end-of-transfer flag (bit 4) and clears both the enable bit and the active bit (bit 1). The exception is a same-cycle descriptor load or an enable write, which sets the enable bit again.
- R6: `statusRd` clears bits 4, 5 and 6 in the next cycle. A set event in the same cycle takes priority, so the flag it sets stays at one.
- R7: A control write of one sets the enable bit. A control write of zero that arrives while the channel is enabled, active, and `fifoEmpty` is low raises `drainReq` and keeps the enable bit high. The cycle after `fifoEmpty` is seen high, the enable bit and `drainReq` both drop.
- R8: A control write of zero under any other condition clears the enable bit in the next cycle, and `drainReq` stays low.
- R9: `pktStart` on an enabled channel sets the active bit, and `pktEnd` clears it. A buffer end and a following descriptor load leave the active bit set.
- R10: `nextDescReq` is high exactly when the enable bit is low and `ldNextCtl` is high.
- R11: Status bits 3:2 and 15:7 always read zero.
- R12: When events coincide, the enable bit follows this order of priority: descriptor load first, then a control write of one, then a buffer or device end, then a control write of zero, then drain completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| ctrlWr | input | 1 | Control-register enable write strobe |
| ctrlEnBit | input | 1 | Enable value carried by the control write |
| ldNextCtl | input | 1 | Load-next-descriptor control level |
| descLoad | input | 1 | Descriptor load strobe |
| descEnBit | input | 1 | Enable value carried by the descriptor |
| descCount | input | CNT_W | Byte count carried by the descriptor |
| byteStb | input | 1 | One byte moved |
| pktStart | input | 1 | Channel selected to source a packet |
| pktEnd | input | 1 | Packet transfer finished |
| devEnd | input | 1 | Device-initiated transfer end |
| fifoEmpty | input | 1 | Channel FIFO is empty |
| statusRd | input | 1 | Software read of the status word |
| statusWord | output | 16+CNT_W | Packed status word |
| drainReq | output | 1 | FIFO drain in progress before disable |
| nextDescReq | output | 1 | Request to fetch the next descriptor |

## Verification
The assertions assume that every input is a clean, single-cycle strobe sampled at the clock edge. They also assume that `fifoEmpty` eventually rises once a drain begins, and that `byteStb` moves at most one byte per cycle. The bench drives every strobe for exactly one cycle, away from the clock edge. It raises `fifoEmpty` within two cycles of starting a drain, and otherwise holds `fifoEmpty` high. The bench also builds the simultaneous cases on purpose: a set event together with a read, a descriptor load together with a control write, and a device end together with an enable write. This lets the priority assertions see their guarded conditions.

// File: rtl/dma_chan_status_pkg.sv
package dma_chan_status_pkg;

  localparam int ENABLE_POS  = 0;
  localparam int ACTIVE_POS  = 1;
  localparam int STICKY_BASE = 4;
  localparam int STICKY_NUM  = 3;
  localparam int COUNT_LSB   = 16;

  localparam int ST_END_TR  = 0;
  localparam int ST_END_BUF = 1;
  localparam int ST_DESC_LD = 2;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic clrSticky;
    logic [STICKY_NUM-1:0] setSticky;
  } dpStrobe_t;

endpackage

// File: rtl/dma_chan_status_ctrl.sv
module dma_chan_status_ctrl
  import dma_chan_status_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      ctrlWr,
  input  logic      ctrlEnBit,
  input  logic      ldNextCtl,
  input  logic      descLoad,
  input  logic      descEnBit,
  input  logic      byteStb,
  input  logic      pktStart,
  input  logic      pktEnd,
  input  logic      devEnd,
  input  logic      fifoEmpty,
  input  logic      statusRd,
  input  logic      cntIsZero,
  input  logic      cntIsOne,
  output dpStrobe_t stb,
  output logic      chanEn,
  output logic      chanAct,
  output logic      drainReq,
  output logic      nextDescReq
);

  logic draining;
  logic enNext, actNext, drainNext;
  logic byteOk, bufEnd, devEndOk, enWrite, disWrite, mustDrain;

  assign byteOk    = chanEn && byteStb && !cntIsZero;
  assign bufEnd    = byteOk && cntIsOne && !descLoad;
  assign devEndOk  = chanEn && devEnd;
  assign enWrite   = ctrlWr && ctrlEnBit;
  assign disWrite  = ctrlWr && !ctrlEnBit;
  assign mustDrain = chanEn && chanAct && !fifoEmpty;

  // Enable priority: descriptor, enable write, ends, disable write, drain done
  always_comb begin
    enNext    = chanEn;
    drainNext = draining;
    if (descLoad) begin
      enNext    = descEnBit;
      drainNext = 1'b0;
    end else if (enWrite) begin
      enNext    = 1'b1;
      drainNext = 1'b0;
    end else if (bufEnd || devEndOk) begin
      enNext    = 1'b0;
      drainNext = 1'b0;
    end else if (disWrite) begin
      if (mustDrain) begin
        drainNext = 1'b1;
      end else begin
        enNext    = 1'b0;
        drainNext = 1'b0;
      end
    end else if (draining && fifoEmpty) begin
      enNext    = 1'b0;
      drainNext = 1'b0;
    end
  end

  always_comb begin
    actNext = chanAct;
    if (pktEnd || devEndOk) begin
      actNext = 1'b0;
    end else if (pktStart && chanEn) begin
      actNext = 1'b1;
    end
  end

  always_comb begin
    stb                       = '0;
    stb.loadCnt               = descLoad;
    stb.decCnt                = byteOk && !descLoad;
    stb.clrSticky             = statusRd;
    stb.setSticky[ST_END_TR]  = devEndOk;
    stb.setSticky[ST_END_BUF] = bufEnd;
    stb.setSticky[ST_DESC_LD] = descLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanEn   <= 1'b0;
      chanAct  <= 1'b0;
      draining <= 1'b0;
    end else begin
      chanEn   <= enNext;
      chanAct  <= actNext;
      draining <= drainNext;
    end
  end

  assign drainReq    = draining;
  assign nextDescReq = !chanEn && ldNextCtl;

  p_drain_keeps_en_r7 : assert property (@(posedge clk) disable iff (!rstN)
    draining |-> chanEn);

  p_drain_waits_r7 : assert property (@(posedge clk) disable iff (!rstN)
    (draining && !fifoEmpty && !descLoad && !ctrlWr && !devEnd && !byteStb) |=> chanEn);

  p_devend_stops_r5 : assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && devEnd && !descLoad && !enWrite) |=> (!chanEn && !chanAct));

  p_pktend_clears_r9 : assert property (@(posedge clk) disable iff (!rstN)
    pktEnd |=> !chanAct);

  p_desc_wins_r12 : assert property (@(posedge clk) disable iff (!rstN)
    descLoad |=> (chanEn == $past(descEnBit)));

endmodule

// File: rtl/dma_chan_status_dp.sv
module dma_chan_status_dp
  import dma_chan_status_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dpStrobe_t                 stb,
  input  logic [CNT_W-1:0]          descCount,
  input  logic                      chanEn,
  input  logic                      chanAct,
  output logic                      cntIsZero,
  output logic                      cntIsOne,
  output logic [COUNT_LSB+CNT_W-1:0] statusWord
);

  localparam int WORD_W = COUNT_LSB + CNT_W;

  logic [CNT_W-1:0]      cnt;
  logic [STICKY_NUM-1:0] sticky;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.loadCnt) begin
      cnt <= descCount;
    end else if (stb.decCnt) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign cntIsZero = (cnt == '0);
  assign cntIsOne  = (cnt == CNT_W'(1));

  for (genvar i = 0; i < STICKY_NUM; i++) begin : g_sticky
    always_ff @(posedge clk) begin
      if (!rstN) begin
        sticky[i] <= 1'b0;
      end else if (stb.setSticky[i]) begin
        sticky[i] <= 1'b1;
      end else if (stb.clrSticky) begin
        sticky[i] <= 1'b0;
      end
    end

    p_sticky_hold_r6 : assert property (@(posedge clk) disable iff (!rstN)
      (sticky[i] && !stb.clrSticky) |=> sticky[i]);

    p_set_beats_read_r6 : assert property (@(posedge clk) disable iff (!rstN)
      stb.setSticky[i] |=> sticky[i]);
  end

  always_comb begin
    statusWord = '0;
    statusWord[WORD_W-1:COUNT_LSB] = cnt;
    statusWord[ENABLE_POS] = chanEn;
    statusWord[ACTIVE_POS] = chanAct;
    statusWord[STICKY_BASE +: STICKY_NUM] = sticky;
  end

  p_cnt_step_r3 : assert property (@(posedge clk) disable iff (!rstN)
    stb.decCnt |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_cnt_hold_r3 : assert property (@(posedge clk) disable iff (!rstN)
    (!stb.decCnt && !stb.loadCnt) |=> $stable(cnt));

endmodule

// File: rtl/dma_chan_status.sv
module dma_chan_status
  import dma_chan_status_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      ctrlWr,
  input  logic                      ctrlEnBit,
  input  logic                      ldNextCtl,
  input  logic                      descLoad,
  input  logic                      descEnBit,
  input  logic [CNT_W-1:0]          descCount,
  input  logic                      byteStb,
  input  logic                      pktStart,
  input  logic                      pktEnd,
  input  logic                      devEnd,
  input  logic                      fifoEmpty,
  input  logic                      statusRd,
  output logic [COUNT_LSB+CNT_W-1:0] statusWord,
  output logic                      drainReq,
  output logic                      nextDescReq
);

  dpStrobe_t stb;
  logic chanEn, chanAct, cntIsZero, cntIsOne;

  dma_chan_status_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlEnBit(ctrlEnBit),
    .ldNextCtl(ldNextCtl), .descLoad(descLoad), .descEnBit(descEnBit),
    .byteStb(byteStb), .pktStart(pktStart), .pktEnd(pktEnd), .devEnd(devEnd),
    .fifoEmpty(fifoEmpty), .statusRd(statusRd), .cntIsZero(cntIsZero),
    .cntIsOne(cntIsOne), .stb(stb), .chanEn(chanEn), .chanAct(chanAct),
    .drainReq(drainReq), .nextDescReq(nextDescReq)
  );

  dma_chan_status_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .descCount(descCount),
    .chanEn(chanEn), .chanAct(chanAct), .cntIsZero(cntIsZero),
    .cntIsOne(cntIsOne), .statusWord(statusWord)
  );

  p_idle_fetch_r10 : assert property (@(posedge clk) disable iff (!rstN)
    (nextDescReq && !descLoad && !ctrlWr) |=> !statusWord[ENABLE_POS]);

  p_reserved_zero_r11 : assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[3:2] == 2'b00 && statusWord[15:7] == 9'd0));

endmodule

// File: tb/dma_chan_status_tb_top.sv
module dma_chan_status_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 0, ctrlEnBit = 0, ldNextCtl = 0, descLoad = 0, descEnBit = 0;
  logic [15:0] descCount = '0;
  logic byteStb = 0, pktStart = 0, pktEnd = 0, devEnd = 0, fifoEmpty = 1, statusRd = 0;
  logic [31:0] statusWord;
  logic drainReq, nextDescReq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_chan_status dut_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlEnBit(ctrlEnBit),
    .ldNextCtl(ldNextCtl), .descLoad(descLoad), .descEnBit(descEnBit),
    .descCount(descCount), .byteStb(byteStb), .pktStart(pktStart),
    .pktEnd(pktEnd), .devEnd(devEnd), .fifoEmpty(fifoEmpty),
    .statusRd(statusRd), .statusWord(statusWord), .drainReq(drainReq),
    .nextDescReq(nextDescReq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    ctrlWr = 0; descLoad = 0; byteStb = 0; pktStart = 0;
    pktEnd = 0; devEnd = 0; statusRd = 0;
  endtask

  task automatic load(logic en, logic [15:0] cnt);
    descLoad = 1; descEnBit = en; descCount = cnt;
    tick();
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 status in reset", statusWord, 32'h0);
    rstN = 1;
    tick();
    chk("R1 status after reset", statusWord, 32'h0);
    chk("R1 drainReq", {31'd0, drainReq}, 32'h0);
    chk("R1 nextDescReq", {31'd0, nextDescReq}, 32'h0);
  endtask

  task automatic t_load_count();
    load(1, 16'd3);
    chk("R2 descriptor load", statusWord, 32'h0003_0041);
    ldNextCtl = 1; #1;
    chk("R10 no fetch while enabled", {31'd0, nextDescReq}, 32'h0);
    byteStb = 1; tick();
    chk("R3 count 3->2", statusWord, 32'h0002_0041);
    byteStb = 1; tick();
    byteStb = 1; tick();
    chk("R4 buffer end", statusWord, 32'h0000_0060);
    byteStb = 1; tick();
    chk("R3 byte ignored at zero", statusWord, 32'h0000_0060);
    chk("R10 fetch when idle", {31'd0, nextDescReq}, 32'h1);
    chk("R11 reserved bits", statusWord & 32'h0000_FF8C, 32'h0);
    ldNextCtl = 0;
    statusRd = 1; tick();
    chk("R6 read clears", statusWord, 32'h0);
  endtask

  task automatic t_read_race();
    load(1, 16'd1);
    byteStb = 1; statusRd = 1; tick();
    chk("R6 set beats read", statusWord, 32'h0000_0020);
    statusRd = 1; tick();
    chk("R6 second read clears", statusWord, 32'h0);
  endtask

  task automatic t_devend();
    load(1, 16'd10);
    pktStart = 1; tick();
    chk("R9 active set", statusWord, 32'h000A_0043);
    devEnd = 1; tick();
    chk("R5 device end", statusWord, 32'h000A_0050);
    statusRd = 1; tick();
    chk("R6 clear after device end", statusWord, 32'h000A_0000);
  endtask

  task automatic t_persist();
    load(1, 16'd2);
    pktStart = 1; tick();
    byteStb = 1; tick();
    byteStb = 1; tick();
    chk("R9 active kept at buffer end", statusWord, 32'h0000_0062);
    load(1, 16'd4);
    chk("R9 active kept through reload", statusWord, 32'h0004_0063);
    pktEnd = 1; tick();
    chk("R9 packet end clears active", statusWord, 32'h0004_0061);
    statusRd = 1; tick();
    chk("R6 read after reload", statusWord, 32'h0004_0001);
  endtask

  task automatic t_drain();
    pktStart = 1; tick();
    fifoEmpty = 0;
    ctrlWr = 1; ctrlEnBit = 0; tick();
    chk("R7 enable held while draining", statusWord, 32'h0004_0003);
    chk("R7 drain requested", {31'd0, drainReq}, 32'h1);
    tick();
    chk("R7 still draining", {31'd0, drainReq, statusWord[0]}, 32'h3);
    fifoEmpty = 1; tick();
    chk("R7 enable drops after empty", statusWord, 32'h0004_0002);
    chk("R7 drain request drops", {31'd0, drainReq}, 32'h0);
    pktEnd = 1; tick();
    ctrlWr = 1; ctrlEnBit = 1; tick();
    chk("R7 enable write", statusWord, 32'h0004_0001);
    fifoEmpty = 0;
    ctrlWr = 1; ctrlEnBit = 0; tick();
    chk("R8 immediate disable", statusWord, 32'h0004_0000);
    chk("R8 no drain request", {31'd0, drainReq}, 32'h0);
    fifoEmpty = 1;
    byteStb = 1; tick();
    chk("R3 byte ignored while disabled", statusWord, 32'h0004_0000);
  endtask

  task automatic t_priority();
    ctrlWr = 1; ctrlEnBit = 0;
    descLoad = 1; descEnBit = 1; descCount = 16'd5;
    tick();
    chk("R12 descriptor beats disable", statusWord, 32'h0005_0041);
    devEnd = 1; ctrlWr = 1; ctrlEnBit = 1; tick();
    chk("R12 enable write beats device end", statusWord, 32'h0005_0051);
  endtask

  initial begin
    t_reset();
    t_load_count();
    t_read_race();
    t_devend();
    t_persist();
    t_drain();
    t_priority();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule